// File: doc/BRIEF.md
# Hardware Semaphore Bank with Read-Acquire

This block holds a set of single-bit semaphores that several processors share to arbitrate for common resources. Each semaphore appears as a 32-bit word on a simple register bus. A processor takes a semaphore by reading its word. A zero result means the reader now holds it. A result of one means another agent already holds it, and the reader must try again later. The holder frees the semaphore by writing zero to the same word.

The read is an atomic test-and-set. The old state comes back in bit 0 and the semaphore is set in the same cycle, so two agents can never both see zero. The 64 semaphore words sit in two address windows that are not contiguous. Channels 0 to 7 are in a low window and channels 8 to 63 are in a high window. A build parameter selects a reduced variant in which only channels 0 to 7 exist.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every channel is free, so the first read of each channel returns 0. Read data is 0 and ready is low while no access takes place.
- R2: Channel n, for n from 0 to 7, is decoded at byte offset 0x0C0 + 4*n.
- R3: Channel n, for n from 8 to 63, is decoded at byte offset 0x724 + 4*(n-8). The last channel sits at 0x800.
- R4: A read of a channel returns that channel's prior state in bit 0, with bits 31:1 zero, and leaves the channel held. Two back-to-back reads of a free channel therefore return 0 and then 1.
- R5: A write of the value 0 to a channel frees it.
- R6: A write of any nonzero value to a channel leaves that channel's state unchanged.
- R7: An access to any other offset touches no channel and reads as 0. This covers offsets outside both windows and offsets with bits 1:0 not zero.
- R8: When a read and a write of 0 reach the same channel in one cycle, the release happens first. The read returns 0 and the channel ends up held. When the write in that cycle is nonzero, the read returns the prior state.
- R9: Read data is registered and is valid in the cycle after the strobe. Ready is high in that cycle for every read or write, and low after a cycle with no strobe.
- R10: With the reduced parameter set, channels 8 to 63 are absent. Their offsets read as 0 on every access and are never held.
- R11: Taking or freeing one channel does not change the state of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe; takes the addressed channel |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; zero frees the channel |
| bus_rdata | output | 32 | Registered read data; prior channel state in bit 0 |
| bus_ready | output | 1 | High one cycle after any strobe |

## Verification
The acquire side effect of a read and the release of a write can reach the same channel in the same cycle. The bench provokes this by raising both strobes on one address. It does so once with a held channel and zero write data, and once with nonzero write data. It then judges the returned bit against the release-first rule and probes the final channel state with a follow-up read, which must return 1 in both cases. The same stimulus also runs against the reduced build, where the high-window offsets must stay inert.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LO_BASE  = 'h0C0;
  localparam int unsigned HI_BASE  = 'h724;
  localparam int unsigned LO_COUNT = 8;
  localparam int unsigned WORD_B   = 4;
endpackage

// File: rtl/hwlock_rst_sync.sv
module hwlock_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hwlock_decode.sv
module hwlock_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned LO_BASE   = 'h0C0,
  parameter int unsigned HI_BASE   = 'h724,
  parameter int unsigned LO_COUNT  = 8,
  parameter bit          REDUCED   = 1'b0,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned HI_COUNT = NUM_LOCKS - LO_COUNT;
  localparam logic [ADDR_W-1:0] LO_START = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] LO_END   = ADDR_W'(LO_BASE + 4 * LO_COUNT);
  localparam logic [ADDR_W-1:0] HI_START = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] HI_END   = ADDR_W'(HI_BASE + 4 * HI_COUNT);

  logic              aligned;
  logic              lo_hit;
  logic              hi_hit;
  logic [ADDR_W-1:0] lo_off;
  logic [ADDR_W-1:0] hi_off;
  logic [IDX_W-1:0]  lo_idx;
  logic [IDX_W-1:0]  hi_idx;

  assign aligned = (addr[1:0] == 2'b00);
  assign lo_off  = addr - LO_START;
  assign hi_off  = addr - HI_START;
  assign lo_hit  = aligned && (addr >= LO_START) && (addr < LO_END);
  assign lo_idx  = IDX_W'(lo_off >> 2);

  generate
    if (REDUCED) begin : g_hi_absent
      assign hi_hit = 1'b0;
      assign hi_idx = '0;
    end else begin : g_hi_present
      assign hi_hit = aligned && (addr >= HI_START) && (addr < HI_END);
      assign hi_idx = IDX_W'(hi_off >> 2) + IDX_W'(LO_COUNT);
    end
  endgenerate

  always_comb begin
    hit = lo_hit || hi_hit;
    if (lo_hit)      idx = lo_idx;
    else if (hi_hit) idx = hi_idx;
    else             idx = '0;
  end
endmodule

// File: rtl/hwlock_array.sv
module hwlock_array #(
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned ACTIVE    = 64,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 acq_en,
  input  logic                 rel_en,
  output logic [NUM_LOCKS-1:0] lock_q,
  output logic                 prior
);
  logic [NUM_LOCKS-1:0] sel;

  // The release is applied before the acquire test in the same cycle.
  assign prior = hit && lock_q[idx] && !rel_en;

  generate
    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_ch
      assign sel[i] = hit && (idx == IDX_W'(i));
      if (i < ACTIVE) begin : g_cell
        logic lock_d;
        logic lock_en;
        assign lock_en = sel[i] && (acq_en || rel_en);
        always_comb begin
          lock_d = lock_q[i];
          if (rel_en) lock_d = 1'b0;
          if (acq_en) lock_d = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       lock_q[i] <= 1'b0;
          else if (lock_en) lock_q[i] <= lock_d;
        end
      end else begin : g_none
        logic unused_sel;
        assign unused_sel = sel[i];
        assign lock_q[i]  = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/hwlock_rdata.sv
module hwlock_rdata #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic              prior,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  logic [DATA_W-1:0] rdata_d;
  logic              ready_d;

  always_comb begin
    rdata_d = '0;
    if (rd) rdata_d[0] = prior;
    ready_d = rd || wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      ready <= 1'b0;
    end else begin
      rdata <= rdata_d;
      ready <= ready_d;
    end
  end
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank #(
  parameter int unsigned ADDR_W    = hwlock_pkg::ADDR_W,
  parameter int unsigned DATA_W    = hwlock_pkg::DATA_W,
  parameter int unsigned NUM_LOCKS = 64,
  parameter bit          REDUCED   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready
);
  localparam int unsigned IDX_W  = $clog2(NUM_LOCKS);
  localparam int unsigned ACTIVE = REDUCED ? hwlock_pkg::LO_COUNT : NUM_LOCKS;

  logic                 rst_sync_n;
  logic                 hit;
  logic [IDX_W-1:0]     idx;
  logic                 acq_en;
  logic                 rel_en;
  logic                 prior;
  logic [NUM_LOCKS-1:0] lock_q;

  assign acq_en = bus_rd;
  assign rel_en = bus_wr && (bus_wdata == '0);

  hwlock_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hwlock_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_LOCKS (NUM_LOCKS),
    .LO_BASE   (hwlock_pkg::LO_BASE),
    .HI_BASE   (hwlock_pkg::HI_BASE),
    .LO_COUNT  (hwlock_pkg::LO_COUNT),
    .REDUCED   (REDUCED)
  ) u_dec (
    .addr (bus_addr),
    .hit  (hit),
    .idx  (idx)
  );

  hwlock_array #(
    .NUM_LOCKS (NUM_LOCKS),
    .ACTIVE    (ACTIVE)
  ) u_arr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hit    (hit),
    .idx    (idx),
    .acq_en (acq_en),
    .rel_en (rel_en),
    .lock_q (lock_q),
    .prior  (prior)
  );

  hwlock_rdata #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .prior (prior),
    .rdata (bus_rdata),
    .ready (bus_ready)
  );
endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LOCKS = 64,
  parameter bit          REDUCED   = 1'b0,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 bus_ready,
  input logic                 hit,
  input logic [IDX_W-1:0]     idx,
  input logic [NUM_LOCKS-1:0] lock_q
);
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:1] == '0);

  assert_read_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit) |=> lock_q[$past(idx)]);

  assert_free_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit && !lock_q[idx]) |=> !bus_rdata[0]);

  assert_held_reads_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit && lock_q[idx] && !(bus_wr && bus_wdata == '0)) |=> bus_rdata[0]);

  assert_zero_write_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && hit && bus_wdata == '0) |=> !lock_q[$past(idx)]);

  assert_nonzero_write_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_wdata != '0) |=> $stable(lock_q));

  assert_unmapped_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && (bus_rd || bus_wr)) |=> ($stable(lock_q) && bus_rdata == '0));

  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr && hit && bus_wdata == '0) |=> (!bus_rdata[0] && lock_q[$past(idx)]));

  assert_ready_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> bus_ready);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> (!bus_ready && bus_rdata == '0));

  generate
    if (REDUCED) begin : g_red
      assert_absent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[NUM_LOCKS-1:hwlock_pkg::LO_COUNT] == '0);
    end
  endgenerate
endmodule

bind hwlock_bank hwlock_bank_chk #(
  .DATA_W    (DATA_W),
  .NUM_LOCKS (NUM_LOCKS),
  .REDUCED   (REDUCED)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_ready (bus_ready),
  .hit       (hit),
  .idx       (idx),
  .lock_q    (lock_q)
);

// File: tb/hwlock_bank_tb_top.sv
module hwlock_bank_tb_top;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata_f, rdata_r;
  logic        ready_f, ready_r;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;
  bit  mdl_full [64];
  bit  mdl_red  [64];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  hwlock_bank #(.REDUCED(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_f), .bus_ready(ready_f)
  );

  hwlock_bank #(.REDUCED(1'b1)) dut_red_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_r), .bus_ready(ready_r)
  );

  function automatic int ch_addr(int n);
    return (n < 8) ? ('h0C0 + 4 * n) : ('h724 + 4 * (n - 8));
  endfunction

  function automatic int map_ch(logic [11:0] a, bit red);
    int ia = int'(a);
    if (a[1:0] != 2'b00) return -1;
    if (ia >= 'h0C0 && ia < 'h0E0) return (ia - 'h0C0) / 4;
    if (!red && ia >= 'h724 && ia < 'h804) return 8 + (ia - 'h724) / 4;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One bus cycle applied to both builds; results checked against the model.
  task automatic access(bit r, bit w, int a, logic [31:0] d, string req);
    logic [31:0] exp_f, exp_r;
    int cf, cr;
    @(negedge clk);
    bus_addr = 12'(a); bus_rd = r; bus_wr = w; bus_wdata = d;
    cf = map_ch(12'(a), 1'b0);
    cr = map_ch(12'(a), 1'b1);
    if (w && d == 0 && cf >= 0) mdl_full[cf] = 1'b0;
    if (w && d == 0 && cr >= 0) mdl_red[cr]  = 1'b0;
    exp_f = (r && cf >= 0) ? {31'b0, mdl_full[cf]} : 32'b0;
    exp_r = (r && cr >= 0) ? {31'b0, mdl_red[cr]}  : 32'b0;
    if (r && cf >= 0) mdl_full[cf] = 1'b1;
    if (r && cr >= 0) mdl_red[cr]  = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
    check(rdata_f == exp_f, req, "full rdata", rdata_f, exp_f);
    check(rdata_r == exp_r, req, "reduced rdata", rdata_r, exp_r);
    check(ready_f == (r | w) && ready_r == (r | w), req, "ready",
          {30'b0, ready_f, ready_r}, {30'b0, r | w, r | w});
  endtask

  task automatic t_reset();
    check(rdata_f == 0 && ready_f == 0, "R1", "idle outputs", {rdata_f[30:0], ready_f}, 32'h0);
    for (int n = 0; n < 64; n++) access(1, 0, ch_addr(n), 0, "R1");
    for (int n = 0; n < 64; n++) access(0, 1, ch_addr(n), 0, "R5");
  endtask

  task automatic t_lo_window();
    for (int n = 0; n < 8; n++) begin
      access(1, 0, 'h0C0 + 4 * n, 0, "R2");
      access(1, 0, 'h0C0 + 4 * n, 0, "R4");
    end
    for (int n = 0; n < 8; n++) access(0, 1, 'h0C0 + 4 * n, 0, "R5");
  endtask

  task automatic t_hi_window();
    access(1, 0, 'h724, 0, "R3");
    access(1, 0, 'h724, 0, "R3");
    access(1, 0, 'h800, 0, "R3");
    access(1, 0, 'h800, 0, "R10");
    access(1, 0, 'h7A0, 0, "R3");
    access(0, 1, 'h724, 0, "R5");
    access(0, 1, 'h800, 0, "R5");
    access(0, 1, 'h7A0, 0, "R5");
    access(1, 0, 'h800, 0, "R5");
    access(0, 1, 'h800, 0, "R5");
  endtask

  task automatic t_nonzero_write();
    access(1, 0, ch_addr(3), 0, "R6");
    access(0, 1, ch_addr(3), 32'h1, "R6");
    access(0, 1, ch_addr(3), 32'h8000_0000, "R6");
    access(1, 0, ch_addr(3), 0, "R6");
    access(0, 1, ch_addr(40), 32'hFFFF_FFFF, "R6");
    access(1, 0, ch_addr(40), 0, "R6");
    access(0, 1, ch_addr(3), 0, "R5");
    access(0, 1, ch_addr(40), 0, "R5");
  endtask

  task automatic t_unmapped();
    access(1, 0, 'h0BC, 0, "R7");
    access(1, 0, 'h0E0, 0, "R7");
    access(1, 0, 'h0C2, 0, "R7");
    access(1, 0, 'h804, 0, "R7");
    access(1, 0, 'h720, 0, "R7");
    access(1, 0, 'h0C0, 0, "R7");
    access(0, 1, 'h0C1, 0, "R7");
    access(0, 1, 'h000, 0, "R7");
    access(1, 0, 'h0C0, 0, "R7");
    access(1, 0, 'h0BC, 0, "R7");
    access(0, 1, 'h0C0, 0, "R5");
  endtask

  task automatic t_same_cycle();
    access(1, 0, ch_addr(5), 0, "R8");
    access(1, 1, ch_addr(5), 0, "R8");
    access(1, 0, ch_addr(5), 0, "R8");
    access(1, 1, ch_addr(5), 32'h2, "R8");
    access(1, 1, ch_addr(20), 32'h0, "R8");
    access(1, 0, ch_addr(20), 0, "R8");
    access(0, 1, ch_addr(5), 0, "R5");
    access(0, 1, ch_addr(20), 0, "R5");
  endtask

  task automatic t_idle_ready();
    access(0, 0, ch_addr(0), 0, "R9");
    access(1, 0, ch_addr(1), 0, "R9");
    access(0, 0, ch_addr(1), 0, "R9");
    access(0, 1, ch_addr(1), 0, "R9");
  endtask

  task automatic t_independence();
    access(1, 0, ch_addr(7), 0, "R11");
    access(1, 0, ch_addr(8), 0, "R11");
    access(1, 0, ch_addr(6), 0, "R11");
    access(0, 1, ch_addr(7), 0, "R11");
    access(1, 0, ch_addr(8), 0, "R11");
    access(1, 0, ch_addr(7), 0, "R11");
    access(0, 1, ch_addr(6), 0, "R11");
    access(0, 1, ch_addr(7), 0, "R11");
    access(0, 1, ch_addr(8), 0, "R11");
  endtask

  task automatic t_reduced();
    for (int n = 8; n < 64; n += 11) begin
      access(1, 0, ch_addr(n), 0, "R10");
      access(1, 0, ch_addr(n), 0, "R10");
    end
    for (int n = 8; n < 64; n += 11) access(0, 1, ch_addr(n), 0, "R10");
  endtask

  initial begin
    bus_addr = 12'h0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lo_window();
    t_hi_window();
    t_nonzero_write();
    t_unmapped();
    t_same_cycle();
    t_idle_ready();
    t_independence();
    t_reduced();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule